// File: doc/BRIEF.md
# Multi-Resolution Rectangular Piecewise-Affine Evaluator

This block computes a piecewise-affine map y = g·x + b over the box [-1, 1)^n, in which every region has its own gains and offset. Neighbouring regions need not agree, so the result may jump at a region border. The regions come from a dyadic refinement of the box. The first level halves every axis. Deeper levels split only the cells that need more detail.

A tree built offline sits in an external memory, and a second memory holds n+1 coefficients per region. The block never reads a cell edge. Each tree level takes one more bit, counted from the top, of every coordinate's offset-binary code. Those bits address one of up to 2^n children. The walk stops at a leaf, which gives the region number. A single multiply-accumulate unit then sums the offset and the n products, saturates the sum and pulses `done`. All coordinates are presented together with a `start` strobe. Both memories are read combinationally.

Top module: `mpwar_eval`

## Requirements
- R1: After reset, `done`, `busy`, `y_out` and `region_out` are all zero.
- R2: A coordinate x_j (signed, XW bits, value x_j/2^(XW-1)) is coded offset-binary by inverting its top bit. At tree level k the child index takes bit XW-1-k of coordinate j's code as its bit N_DIM-1-j. The child's address is the node's base plus that index.
- R3: A node word holds a leaf flag in its top bit and a TREE_AW-bit payload below it. The payload is a child base for inner nodes and a region number (its low REG_AW bits) for leaves. The root sits at address 0.
- R4: A node reached at level MAX_LEVEL is taken as a leaf whatever its flag, and its payload is taken as the region number.
- R5: Region r keeps its offset at coefficient address r·(N_DIM+1) and the gain of x_j at r·(N_DIM+1)+1+j. All coefficients are signed COEF_W bits with CFRAC fraction bits. The result is floor((Σ g_j·x_j + b·2^(XW-1)) / 2^CFRAC).
- R6: The result saturates to the signed XW-bit range [-2^(XW-1), 2^(XW-1)-1].
- R7: For a leaf at depth d, `done` rises d+N_DIM+1 clock edges after the edge that accepts `start`. It stays high for one cycle. `y_out` and `region_out` change only with `done` and hold until the next `done`.
- R8: `busy` is high from the edge that accepts `start` until `done` rises. A `start` seen while `busy` is high is ignored and changes neither the result nor the latency.
- R9: `busy` is low in the cycle where `done` is high, so a `start` in that same cycle is accepted and begins a new evaluation.
- R10: `region_out` gives the region number of the leaf that was reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Strobe that begins an evaluation when idle |
| x_in | input | N_DIM*XW | Coordinates, coordinate j in bits j*XW +: XW, signed |
| busy | output | 1 | Evaluation in progress |
| tree_addr | output | TREE_AW | Tree memory read address |
| tree_word | input | TREE_AW+1 | Tree memory word: leaf flag and payload |
| coef_addr | output | REG_AW+$clog2(N_DIM+1) | Coefficient memory read address |
| coef_word | input | COEF_W | Signed coefficient |
| done | output | 1 | One-cycle result strobe |
| y_out | output | XW | Saturated signed result |
| region_out | output | REG_AW | Region number of the evaluated point |

## Verification
The finishing `done` of one evaluation and the acceptance of the next `start` can fall in the same cycle. The sweep therefore launches every new point in exactly the cycle where the previous result appears. For each point the bench checks the result, the region and the edge count, all computed from the tree geometry and the affine formula. A separate run holds `start` high during a busy walk. It then confirms that the first point's value and latency come through unchanged, and that the block accepts the next `start` once it is idle.

// File: rtl/mpwar_pkg.sv
package mpwar_pkg;
  typedef enum logic [0:0] {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;
endpackage

// File: rtl/mpwar_locator.sv
module mpwar_locator #(
  parameter int N_DIM     = 2,
  parameter int XW        = 8,
  parameter int MAX_LEVEL = 4,
  parameter int TREE_AW   = 6,
  parameter int REG_AW    = 4,
  localparam int LV_W     = $clog2(MAX_LEVEL + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic [N_DIM*XW-1:0]   offs_flat,
  output logic [TREE_AW-1:0]    tree_addr,
  input  logic [TREE_AW:0]      tree_word,
  output logic                  walking,
  output logic                  resolve,
  output logic [LV_W-1:0]       level,
  output logic [REG_AW-1:0]     region
);
  import mpwar_pkg::*;

  walk_state_e          state_q;
  logic [TREE_AW-1:0]   node_q;
  logic [LV_W-1:0]      level_q;
  logic                 step;
  logic                 leaf_now;
  logic [TREE_AW-1:0]   child_addr;

  // Child index: bit (XW-1-lvl) of coordinate j lands at index bit N_DIM-1-j.
  function automatic logic [N_DIM-1:0] child_index(
    input logic [N_DIM*XW-1:0] o,
    input logic [LV_W-1:0]     lvl
  );
    logic [N_DIM-1:0] idx;
    int               pos;
    pos = XW - 1 - int'(lvl);
    if (pos < 0) pos = 0;
    for (int j = 0; j < N_DIM; j++) begin
      idx[N_DIM-1-j] = o[j*XW + pos];
    end
    return idx;
  endfunction

  assign step       = (state_q == WALK_IDLE && go) || (state_q == WALK_RUN);
  assign leaf_now   = tree_word[TREE_AW] || (level_q == LV_W'(MAX_LEVEL));
  assign resolve    = step && leaf_now;
  assign tree_addr  = (state_q == WALK_RUN) ? node_q : '0;
  assign child_addr = tree_word[TREE_AW-1:0] + TREE_AW'(child_index(offs_flat, level_q));
  assign walking    = (state_q == WALK_RUN);
  assign level      = level_q;
  assign region     = tree_word[REG_AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      node_q  <= '0;
      level_q <= '0;
    end else if (step) begin
      if (leaf_now) begin
        state_q <= WALK_IDLE;
        node_q  <= '0;
        level_q <= '0;
      end else begin
        state_q <= WALK_RUN;
        node_q  <= child_addr;
        level_q <= level_q + LV_W'(1);
      end
    end
  end
endmodule

// File: rtl/mpwar_mac.sv
module mpwar_mac #(
  parameter int N_DIM    = 2,
  parameter int XW       = 8,
  parameter int COEF_W   = 12,
  parameter int CFRAC    = 8,
  parameter int REG_AW   = 4,
  localparam int KW      = $clog2(N_DIM + 1),
  localparam int CA_W    = REG_AW + KW,
  localparam int ACC_W   = COEF_W + XW + KW + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [REG_AW-1:0]        load_region,
  input  logic [N_DIM*XW-1:0]      x_flat,
  output logic [CA_W-1:0]          coef_addr,
  input  logic signed [COEF_W-1:0] coef_word,
  output logic                     active,
  output logic                     last,
  output logic                     done,
  output logic signed [XW-1:0]     y_out,
  output logic [REG_AW-1:0]        region_out
);
  localparam logic signed [ACC_W-1:0] Y_MAX = ACC_W'((2 ** (XW - 1)) - 1);
  localparam logic signed [ACC_W-1:0] Y_MIN = -Y_MAX - ACC_W'(1);

  logic                    active_q;
  logic [KW-1:0]           k_q;
  logic [REG_AW-1:0]       region_q;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_next;

  // Term k: offset scaled to the input's fraction for k=0, else gain times x_(k-1).
  function automatic logic signed [ACC_W-1:0] term_of(
    input logic [KW-1:0]            k,
    input logic signed [COEF_W-1:0] c,
    input logic [N_DIM*XW-1:0]      xf
  );
    logic signed [ACC_W-1:0] ce;
    logic signed [ACC_W-1:0] xe;
    logic signed [XW-1:0]    xv;
    ce = {{(ACC_W-COEF_W){c[COEF_W-1]}}, c};
    if (k == '0) begin
      return ce <<< (XW - 1);
    end
    xv = xf[(int'(k) - 1) * XW +: XW];
    xe = {{(ACC_W-XW){xv[XW-1]}}, xv};
    return ce * xe;
  endfunction

  function automatic logic signed [XW-1:0] saturate(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] s;
    s = a >>> CFRAC;
    if (s > Y_MAX) return Y_MAX[XW-1:0];
    if (s < Y_MIN) return Y_MIN[XW-1:0];
    return s[XW-1:0];
  endfunction

  assign acc_next  = acc_q + term_of(k_q, coef_word, x_flat);
  assign coef_addr = CA_W'(region_q) * CA_W'(N_DIM + 1) + CA_W'(k_q);
  assign active    = active_q;
  assign last      = active_q && (k_q == KW'(N_DIM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      k_q        <= '0;
      region_q   <= '0;
      acc_q      <= '0;
      done       <= 1'b0;
      y_out      <= '0;
      region_out <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        active_q <= 1'b1;
        k_q      <= '0;
        acc_q    <= '0;
        region_q <= load_region;
      end else if (active_q) begin
        acc_q <= acc_next;
        if (last) begin
          active_q   <= 1'b0;
          done       <= 1'b1;
          y_out      <= saturate(acc_next);
          region_out <= region_q;
        end else begin
          k_q <= k_q + KW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mpwar_eval.sv
module mpwar_eval #(
  parameter int N_DIM     = 2,
  parameter int XW        = 8,
  parameter int MAX_LEVEL = 4,
  parameter int TREE_AW   = 6,
  parameter int REG_AW    = 4,
  parameter int COEF_W    = 12,
  parameter int CFRAC     = 8,
  localparam int KW       = $clog2(N_DIM + 1),
  localparam int CA_W     = REG_AW + KW,
  localparam int LV_W     = $clog2(MAX_LEVEL + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [N_DIM*XW-1:0]      x_in,
  output logic                     busy,
  output logic [TREE_AW-1:0]       tree_addr,
  input  logic [TREE_AW:0]         tree_word,
  output logic [CA_W-1:0]          coef_addr,
  input  logic signed [COEF_W-1:0] coef_word,
  output logic                     done,
  output logic signed [XW-1:0]     y_out,
  output logic [REG_AW-1:0]        region_out
);
  logic [N_DIM*XW-1:0] x_q;
  logic [N_DIM*XW-1:0] x_src;
  logic [N_DIM*XW-1:0] offs_now;
  logic                accept;
  logic                loc_walking;
  logic                loc_resolve;
  logic [LV_W-1:0]     loc_level;
  logic [REG_AW-1:0]   loc_region;
  logic                mac_active;
  logic                mac_last;

  assign busy   = loc_walking | mac_active;
  assign accept = start && !busy;
  assign x_src  = busy ? x_q : x_in;

  for (genvar j = 0; j < N_DIM; j++) begin : g_offs
    assign offs_now[j*XW +: XW] = x_src[j*XW +: XW] ^ {1'b1, {(XW-1){1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) x_q <= '0;
    else if (accept) x_q <= x_in;
  end

  mpwar_locator #(
    .N_DIM(N_DIM), .XW(XW), .MAX_LEVEL(MAX_LEVEL),
    .TREE_AW(TREE_AW), .REG_AW(REG_AW)
  ) u_loc (
    .clk(clk), .rst_n(rst_n), .go(accept), .offs_flat(offs_now),
    .tree_addr(tree_addr), .tree_word(tree_word), .walking(loc_walking),
    .resolve(loc_resolve), .level(loc_level), .region(loc_region)
  );

  mpwar_mac #(
    .N_DIM(N_DIM), .XW(XW), .COEF_W(COEF_W), .CFRAC(CFRAC), .REG_AW(REG_AW)
  ) u_mac (
    .clk(clk), .rst_n(rst_n), .load(loc_resolve), .load_region(loc_region),
    .x_flat(x_q), .coef_addr(coef_addr), .coef_word(coef_word),
    .active(mac_active), .last(mac_last), .done(done), .y_out(y_out),
    .region_out(region_out)
  );
endmodule

// File: rtl/mpwar_eval_chk.sv
module mpwar_eval_chk #(
  parameter int MAX_LEVEL = 4,
  parameter int LV_W      = 3,
  parameter int XW        = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [XW-1:0]   y_out,
  input logic            loc_resolve,
  input logic [LV_W-1:0] loc_level,
  input logic            mac_active,
  input logic            mac_last
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_Y_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(y_out)); // R7
  AST_START_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R8
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    loc_level <= LV_W'(MAX_LEVEL)); // R4
  AST_MAC_FOLLOWS_LEAF: assert property (@(posedge clk) disable iff (!rst_n)
    loc_resolve |=> mac_active); // R5
  AST_LAST_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    mac_last |=> done); // R7
endmodule

bind mpwar_eval mpwar_eval_chk #(
  .MAX_LEVEL(MAX_LEVEL), .LV_W(LV_W), .XW(XW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .y_out(y_out), .loc_resolve(loc_resolve), .loc_level(loc_level),
  .mac_active(mac_active), .mac_last(mac_last)
);

// File: tb/tb_mpwar_eval.sv
module tb_mpwar_eval;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [15:0]       x_in = '0;
  logic              busy;
  logic [5:0]        tree_addr;
  logic [6:0]        tree_word;
  logic [5:0]        coef_addr;
  logic signed [11:0] coef_word;
  logic              done;
  logic signed [7:0] y_out;
  logic [3:0]        region_out;

  logic [6:0]        tree_mem [0:63];
  logic [11:0]       coef_mem [0:63];
  int                errors = 0;
  int                checks = 0;

  always #10 clk = ~clk;

  assign tree_word = tree_mem[tree_addr];
  assign coef_word = coef_mem[coef_addr];

  mpwar_eval dut (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .busy(busy),
    .tree_addr(tree_addr), .tree_word(tree_word), .coef_addr(coef_addr),
    .coef_word(coef_word), .done(done), .y_out(y_out), .region_out(region_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int coef_of(input int r, input int k);
    if (k == 0) return ((r * 59 + 13) % 401) - 200;
    if (k == 1) return ((r * 173) % 1201) - 600;
    return ((r * 311 + 97) % 1201) - 600;
  endfunction

  // Geometry of the bench tree, restated from the offset-binary codes.
  function automatic void locate(input int a0, input int a1, output int reg_n, output int depth);
    int o0, o1, q;
    o0 = a0 + 128;
    o1 = a1 + 128;
    q = ((o0 >> 7) & 1) * 2 + ((o1 >> 7) & 1);
    if (q != 3) begin reg_n = q; depth = 1; return; end
    q = ((o0 >> 6) & 1) * 2 + ((o1 >> 6) & 1);
    if (q != 3) begin reg_n = 3 + q; depth = 2; return; end
    q = ((o0 >> 5) & 1) * 2 + ((o1 >> 5) & 1);
    if (q != 3) begin reg_n = 6 + q; depth = 3; return; end
    q = ((o0 >> 4) & 1) * 2 + ((o1 >> 4) & 1);
    reg_n = 9 + q;
    depth = 4;
  endfunction

  function automatic int expect_y(input int a0, input int a1, input int r);
    int acc, s;
    acc = coef_of(r, 1) * a0 + coef_of(r, 2) * a1 + coef_of(r, 0) * 128;
    s = acc >>> 8;
    if (s > 127) s = 127;
    if (s < -128) s = -128;
    return s;
  endfunction

  // Called at a negedge; drives start there, returns at the negedge where done is seen.
  task automatic run_point(input int a0, input int a1, input bit poke, input int b0, input int b1);
    int c, r, d, ey;
    start = 1'b1;
    x_in = {a1[7:0], a0[7:0]};
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    c = 1;
    chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
    while (!done && c < 40) begin
      if (poke && c == 2) begin
        start = 1'b1;
        x_in = {b1[7:0], b0[7:0]};
      end else if (poke && c == 3) begin
        start = 1'b0;
      end
      @(negedge clk);
      c++;
    end
    locate(a0, a1, r, d);
    ey = expect_y(a0, a1, r);
    chk(c - 1 == d + 3, "R7 latency", c - 1, d + 3);
    chk(int'(y_out) == ey, poke ? "R8 ignored start result" : "R5 R6 result", int'(y_out), ey);
    chk(int'(region_out) == r, "R2 R3 R4 R10 region", int'(region_out), r);
    chk(busy == 1'b0, "R9 idle at done", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      tree_mem[i] = '0;
      coef_mem[i] = '0;
    end
    // R3: {leaf, payload}; R4: level-4 nodes 13..16 carry flag 0 yet are leaves.
    tree_mem[0] = {1'b0, 6'd1};
    tree_mem[1] = {1'b1, 6'd0};
    tree_mem[2] = {1'b1, 6'd1};
    tree_mem[3] = {1'b1, 6'd2};
    tree_mem[4] = {1'b0, 6'd5};
    tree_mem[5] = {1'b1, 6'd3};
    tree_mem[6] = {1'b1, 6'd4};
    tree_mem[7] = {1'b1, 6'd5};
    tree_mem[8] = {1'b0, 6'd9};
    tree_mem[9]  = {1'b1, 6'd6};
    tree_mem[10] = {1'b1, 6'd7};
    tree_mem[11] = {1'b1, 6'd8};
    tree_mem[12] = {1'b0, 6'd13};
    for (int i = 0; i < 4; i++) tree_mem[13 + i] = {1'b0, 6'(9 + i)};
    for (int r = 0; r < 13; r++) begin
      for (int k = 0; k < 3; k++) begin
        int v;
        v = coef_of(r, k);
        coef_mem[r * 3 + k] = v[11:0];
      end
    end

    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(y_out == 8'sd0, "R1 y", int'(y_out), 0);
    chk(region_out == 4'd0, "R1 region", int'(region_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep; each new point launches in the cycle the previous done shows (R9).
    for (int i = 0; i < 32; i++) begin
      for (int j = 0; j < 32; j++) begin
        int a0, a1;
        a0 = -128 + 8 * i + ((i % 2) * 7);
        a1 = -128 + 8 * j + ((j % 2) * 7);
        run_point(a0, a1, 1'b0, 0, 0);
      end
    end

    // R8: start during a busy walk is ignored.
    @(negedge clk);
    run_point(127, 127, 1'b1, -100, 100);
    @(negedge clk);
    chk(done == 1'b0, "R7 single-cycle done", int'(done), 0);
    run_point(-100, 100, 1'b0, 0, 0);
    run_point(100, -50, 1'b1, -128, -128);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule